// File: doc/BRIEF.md
# Masked Associative Memory Array

The block is a small content-addressable memory of 64-bit words. Each word has a two-bit type code that decides whether it may take part in a search. A host loads a search key, two mask words and a control word through one operation port. Entries can also be written, read back and retyped at a given address. Loading the key, either mask or the control word starts a search, and so does an explicit search operation. The search compares the key against every entry in parallel and registers a hit flag, a several-hits flag, the lowest matching address and the associated (non-compared) part of the winning word.

The control word splits every word into a compared low field and an associated high field, in 16-bit steps. It also picks which mask, if any, removes bits from the comparison. On a write, a separately chosen mask protects bits of the stored word from change. A two-state controller (IDLE, EVAL) takes one cycle to evaluate each search and raises `busy` for that cycle.

Top module: `assoc_cam`

## Requirements
- R1: After reset every entry has type Empty, both masks, the key and the control word are zero, and `match`, `multi_match`, `match_addr`, `assoc_data` and `busy` are low or zero.
- R2: The type code is {skip, empty}: 2'b00 Valid, 2'b01 Empty, 2'b10 Skip, 2'b11 Random access. Only Valid entries can match.
- R3: Op codes 0 (load key), 1 (load mask A), 2 (load mask B), 3 (load control) and 4 (search) start a search. `busy` is high for exactly the one cycle after the accepting edge. The new results are visible once `busy` falls.
- R4: `match` is high when at least one entry matches. `match_addr` is then the lowest matching index, and it is zero when nothing matches.
- R5: `multi_match` is high exactly when two or more entries match. It is never high without `match`.
- R6: Control bits [4:3] choose the compare mask: 1 selects mask A, 2 selects mask B, and 0 or 3 selects none. A bit set in the chosen mask is left out of the comparison.
- R7: Op code 5 writes `op_data` and type `op_type` at `op_addr`. `op_protect` (1 = mask A, 2 = mask B, 0 or 3 = none) chooses a mask whose set bits keep their stored value.
- R8: Control bits [2:0] give N, the count of 16-bit associated segments at the top of the word. Values above 4 count as 4. The top 16*N bits are never compared. After a hit, `assoc_data` holds those bits of the winning entry with all other bits zero. Without a hit, `assoc_data` is zero.
- R9: Op code 6 (read) shows the word and type at `op_addr` on `rd_data`/`rd_type` after the accepting edge. Op code 7 sets only the type of the entry from `op_type`.
- R10: The search outputs change only in the cycle that ends a search. Writes, reads and type changes leave them as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation code |
| op_addr | input | AW | Entry address for write, read and type change |
| op_data | input | WIDTH | Key, mask, control or entry data |
| op_type | input | 2 | Type code for write and type change |
| op_protect | input | 2 | Write-protect mask select |
| busy | output | 1 | Search evaluation in progress |
| match | output | 1 | At least one entry matched |
| multi_match | output | 1 | Two or more entries matched |
| match_addr | output | AW | Lowest matching index |
| assoc_data | output | WIDTH | Associated field of the winning entry |
| rd_data | output | WIDTH | Data of the last read entry |
| rd_type | output | 2 | Type of the last read entry |

## Verification
The assertions take for granted that no operation is presented while `busy` is high. The block ignores such operations, and the stability and single-cycle checks depend on that. The bench task that drives every operation holds `op_valid` low until it has seen `busy` fall, so the stimulus never breaks this rule. The sweeps cover every split value including a clamped one, every mask selection and every entry type, with duplicated words to exercise the several-hits case.

// File: rtl/cam_pkg.sv
package cam_pkg;

    typedef enum logic [2:0] {
        OP_LD_KEY   = 3'd0,
        OP_LD_MASKA = 3'd1,
        OP_LD_MASKB = 3'd2,
        OP_LD_CTRL  = 3'd3,
        OP_SEARCH   = 3'd4,
        OP_WRITE    = 3'd5,
        OP_READ     = 3'd6,
        OP_SET_TYPE = 3'd7
    } cam_op_e;

    // {skip, empty}
    typedef enum logic [1:0] {
        ET_VALID = 2'b00,
        ET_EMPTY = 2'b01,
        ET_SKIP  = 2'b10,
        ET_RAND  = 2'b11
    } entry_type_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_EVAL = 1'b1
    } cam_state_e;

endpackage

// File: rtl/cam_store.sv
module cam_store #(
    parameter int ENTRIES = 8,
    parameter int WIDTH   = 64,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            ty_en,
    input  logic [AW-1:0]                   addr,
    input  logic [WIDTH-1:0]                wr_data,
    input  logic [WIDTH-1:0]                wr_keep,
    input  logic [1:0]                      wr_type,
    input  logic                            rd_en,
    output logic [ENTRIES-1:0][WIDTH-1:0]   ent_data,
    output logic [ENTRIES-1:0][1:0]         ent_type,
    output logic [WIDTH-1:0]                rd_data,
    output logic [1:0]                      rd_type
);
    import cam_pkg::*;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic sel;
        assign sel = (addr == AW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_data[g] <= '0;
                ent_type[g] <= ET_EMPTY;
            end else begin
                if (wr_en && sel) begin
                    ent_data[g] <= (ent_data[g] & wr_keep) | (wr_data & ~wr_keep);
                end
                if ((wr_en || ty_en) && sel) begin
                    ent_type[g] <= wr_type;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_type <= ET_EMPTY;
        end else if (rd_en) begin
            rd_data <= ent_data[addr];
            rd_type <= ent_type[addr];
        end
    end

endmodule

// File: rtl/cam_match.sv
module cam_match #(
    parameter int ENTRIES = 8,
    parameter int WIDTH   = 64
) (
    input  logic [ENTRIES-1:0][WIDTH-1:0] ent_data,
    input  logic [ENTRIES-1:0][1:0]       ent_type,
    input  logic [WIDTH-1:0]              key,
    input  logic [WIDTH-1:0]              care,
    output logic [ENTRIES-1:0]            hit
);
    import cam_pkg::*;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_line
        logic eligible;
        logic equal;
        assign eligible = (ent_type[g] == ET_VALID);
        assign equal    = ~|((ent_data[g] ^ key) & care);
        assign hit[g]   = eligible && equal;
    end

endmodule

// File: rtl/cam_prio.sv
module cam_prio #(
    parameter int ENTRIES = 8,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] hit,
    output logic               any,
    output logic               several,
    output logic [AW-1:0]      idx
);
    localparam logic [ENTRIES-1:0] ONE = {{(ENTRIES-1){1'b0}}, 1'b1};

    assign any     = |hit;
    assign several = |(hit & (hit - ONE));

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit[i]) idx = AW'(i);
        end
    end

endmodule

// File: rtl/assoc_cam.sv
module assoc_cam #(
    parameter int ENTRIES = 8,
    parameter int WIDTH   = 64,
    parameter int SEG_W   = 16,
    localparam int AW      = $clog2(ENTRIES),
    localparam int NSEG    = WIDTH / SEG_W,
    localparam int SPLIT_W = $clog2(NSEG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [AW-1:0]    op_addr,
    input  logic [WIDTH-1:0] op_data,
    input  logic [1:0]       op_type,
    input  logic [1:0]       op_protect,
    output logic             busy,
    output logic             match,
    output logic             multi_match,
    output logic [AW-1:0]    match_addr,
    output logic [WIDTH-1:0] assoc_data,
    output logic [WIDTH-1:0] rd_data,
    output logic [1:0]       rd_type
);
    import cam_pkg::*;

    cam_state_e state_q, state_d;

    logic [WIDTH-1:0]   key_q, mask_a_q, mask_b_q;
    logic [SPLIT_W-1:0] split_q;
    logic [1:0]         csel_q;

    logic accept, trigger;
    assign accept  = op_valid && (state_q == S_IDLE);
    assign trigger = accept && (op_code <= OP_SEARCH);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (trigger) state_d = S_EVAL;
            S_EVAL: state_d = S_IDLE;
        endcase
    end

    // output process
    always_comb begin
        busy = (state_q == S_EVAL);
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q    <= '0;
            mask_a_q <= '0;
            mask_b_q <= '0;
            split_q  <= '0;
            csel_q   <= '0;
        end else if (accept) begin
            unique case (op_code)
                OP_LD_KEY:   key_q    <= op_data;
                OP_LD_MASKA: mask_a_q <= op_data;
                OP_LD_MASKB: mask_b_q <= op_data;
                OP_LD_CTRL: begin
                    split_q <= op_data[SPLIT_W-1:0];
                    csel_q  <= op_data[SPLIT_W+1:SPLIT_W];
                end
                default: ;
            endcase
        end
    end

    function automatic logic [WIDTH-1:0] pick_mask(input logic [1:0] s,
                                                   input logic [WIDTH-1:0] a,
                                                   input logic [WIDTH-1:0] b);
        unique case (s)
            2'd1:    return a;
            2'd2:    return b;
            default: return '0;
        endcase
    endfunction

    // split and care vector
    logic [SPLIT_W-1:0] split_eff;
    logic [WIDTH-1:0]   cam_field, care;
    assign split_eff = (split_q > SPLIT_W'(NSEG)) ? SPLIT_W'(NSEG) : split_q;
    assign cam_field = {WIDTH{1'b1}} >> (SEG_W * int'(split_eff));
    assign care      = cam_field & ~pick_mask(csel_q, mask_a_q, mask_b_q);

    // storage
    logic [ENTRIES-1:0][WIDTH-1:0] ent_data;
    logic [ENTRIES-1:0][1:0]       ent_type;

    cam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept && op_code == OP_WRITE),
        .ty_en   (accept && op_code == OP_SET_TYPE),
        .addr    (op_addr),
        .wr_data (op_data),
        .wr_keep (pick_mask(op_protect, mask_a_q, mask_b_q)),
        .wr_type (op_type),
        .rd_en   (accept && op_code == OP_READ),
        .ent_data(ent_data),
        .ent_type(ent_type),
        .rd_data (rd_data),
        .rd_type (rd_type)
    );

    logic [ENTRIES-1:0] hit;
    cam_match #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_match (
        .ent_data(ent_data),
        .ent_type(ent_type),
        .key     (key_q),
        .care    (care),
        .hit     (hit)
    );

    logic          any, several;
    logic [AW-1:0] idx;
    cam_prio #(.ENTRIES(ENTRIES)) u_prio (
        .hit    (hit),
        .any    (any),
        .several(several),
        .idx    (idx)
    );

    // status register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match       <= 1'b0;
            multi_match <= 1'b0;
            match_addr  <= '0;
            assoc_data  <= '0;
        end else if (state_q == S_EVAL) begin
            match       <= any;
            multi_match <= several;
            match_addr  <= any ? idx : '0;
            assoc_data  <= any ? (ent_data[idx] & ~cam_field) : '0;
        end
    end

endmodule

// File: rtl/cam_checker.sv
module cam_checker #(
    parameter int AW    = 3,
    parameter int WIDTH = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic             busy,
    input logic             match,
    input logic             multi_match,
    input logic [AW-1:0]    match_addr,
    input logic [WIDTH-1:0] assoc_data
);

    assert_multi_implies_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        multi_match |-> match);

    assert_addr_zero_on_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !match |-> (match_addr == '0));

    assert_assoc_zero_on_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !match |-> (assoc_data == '0));

    assert_trigger_starts_eval_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_code <= 3'd4) |=> busy);

    assert_eval_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(match) && $stable(multi_match) &&
                   $stable(match_addr) && $stable(assoc_data)));

endmodule

bind assoc_cam cam_checker #(.AW(AW), .WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .busy       (busy),
    .match      (match),
    .multi_match(multi_match),
    .match_addr (match_addr),
    .assoc_data (assoc_data)
);

// File: tb/assoc_cam_tb.sv
module assoc_cam_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int AW = 3;
    localparam int W  = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [2:0]    op_code = '0;
    logic [AW-1:0] op_addr = '0;
    logic [W-1:0]  op_data = '0;
    logic [1:0]    op_type = '0;
    logic [1:0]    op_protect = '0;
    logic          busy, match, multi_match;
    logic [AW-1:0] match_addr;
    logic [W-1:0]  assoc_data, rd_data;
    logic [1:0]    rd_type;

    always #(CLK_PERIOD/2) clk = ~clk;

    assoc_cam #(.ENTRIES(N), .WIDTH(W), .SEG_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .op_data(op_data), .op_type(op_type),
        .op_protect(op_protect), .busy(busy), .match(match),
        .multi_match(multi_match), .match_addr(match_addr),
        .assoc_data(assoc_data), .rd_data(rd_data), .rd_type(rd_type)
    );

    int n_checks = 0;
    int n_fails  = 0;

    // reference state
    logic [W-1:0] m_data [N];
    logic [1:0]   m_type [N];
    logic [W-1:0] m_key, m_ma, m_mb;
    int           m_split, m_csel;

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int i);
        return {16'hC000 | 16'(i), 16'(i * 37 + 5), 16'h5A00 ^ 16'(i), 16'h0100 + 16'(i)};
    endfunction

    function automatic logic [W-1:0] sel_mask(input int s);
        if (s == 1) return m_ma;
        if (s == 2) return m_mb;
        return '0;
    endfunction

    task automatic expect_search(input string tag);
        int segs, hits, first;
        logic [W-1:0] camf, care, sm, exp_assoc;
        segs = (m_split > 4) ? 4 : m_split;
        sm = sel_mask(m_csel);
        for (int b = 0; b < W; b++) begin
            camf[b] = (b < W - 16 * segs);
            care[b] = camf[b] && !sm[b];
        end
        hits = 0; first = -1;
        for (int i = 0; i < N; i++) begin
            if (m_type[i] == 2'b00 && ((m_data[i] ^ m_key) & care) == '0) begin
                hits++;
                if (first < 0) first = i;
            end
        end
        exp_assoc = (first >= 0) ? (m_data[first] & ~camf) : '0;
        check(match == (hits > 0), {"R4 match ", tag}, W'(match), W'(hits > 0));
        check(multi_match == (hits > 1), {"R5 multi ", tag}, W'(multi_match), W'(hits > 1));
        check(match_addr == AW'((first < 0) ? 0 : first), {"R4 addr ", tag},
              W'(match_addr), W'((first < 0) ? 0 : first));
        check(assoc_data == exp_assoc, {"R8 assoc ", tag}, assoc_data, exp_assoc);
    endtask

    task automatic do_op(input logic [2:0] code, input int addr, input logic [W-1:0] data,
                         input logic [1:0] ty, input logic [1:0] prot);
        logic [W-1:0] keep;
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_addr = AW'(addr);
        op_data = data; op_type = ty; op_protect = prot;
        keep = sel_mask(int'(prot));
        @(negedge clk);
        op_valid = 1'b0;
        case (code)
            3'd0: m_key = data;
            3'd1: m_ma = data;
            3'd2: m_mb = data;
            3'd3: begin m_split = int'(data[2:0]); m_csel = int'(data[4:3]); end
            3'd5: begin m_data[addr] = (m_data[addr] & keep) | (data & ~keep); m_type[addr] = ty; end
            3'd7: m_type[addr] = ty;
            default: ;
        endcase
        if (code <= 3'd4) begin
            check(busy == 1'b1, "R3 busy raised", W'(busy), 64'd1);
            @(negedge clk);
            check(busy == 1'b0, "R3 busy one cycle", W'(busy), 64'd0);
        end else begin
            check(busy == 1'b0, "R3 no busy for non-search op", W'(busy), 64'd0);
        end
    endtask

    task automatic read_check(input int addr, input string req);
        do_op(3'd6, addr, '0, 2'b00, 2'b00);
        check(rd_data == m_data[addr], {req, " read data"}, rd_data, m_data[addr]);
        check(rd_type == m_type[addr], {req, " read type"}, W'(rd_type), W'(m_type[addr]));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [1:0] f0, f1;
        logic [AW-1:0] a0;
        logic [W-1:0] d0;
        for (int i = 0; i < N; i++) begin m_data[i] = '0; m_type[i] = 2'b01; end
        m_key = '0; m_ma = '0; m_mb = '0; m_split = 0; m_csel = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!match && !multi_match && !busy, "R1 flags after reset",
              W'({busy, multi_match, match}), 64'd0);
        check(match_addr == '0 && assoc_data == '0, "R1 status zero", assoc_data, 64'd0);
        for (int i = 0; i < N; i++) read_check(i, "R1 empty entry");

        // R2 all empty: no match on zero key
        do_op(3'd4, 0, '0, 2'b00, 2'b00);
        expect_search("R2 all empty");

        // R9 fill entries as Valid
        for (int i = 0; i < N; i++) do_op(3'd5, i, pat(i), 2'b00, 2'b00);
        for (int i = 0; i < N; i++) read_check(i, "R9");

        do_op(3'd1, 0, 64'h0000_0000_0000_FFFF, 2'b00, 2'b00);
        do_op(3'd2, 0, 64'hFFFF_0000_0000_0000, 2'b00, 2'b00);

        // R6/R8 sweep: split (incl. clamped 5), compare mask select, key
        for (int sp = 0; sp <= 5; sp++) begin
            for (int cs = 0; cs < 4; cs++) begin
                do_op(3'd3, 0, W'((cs << 3) | sp), 2'b00, 2'b00);
                expect_search("R6 ctrl load");
                for (int k = 0; k < N; k++) begin
                    do_op(3'd0, 0, pat(k) ^ ((k % 2) ? 64'h1 : 64'h0001_0000_0000_0000),
                          2'b00, 2'b00);
                    expect_search("R6 sweep");
                end
            end
        end

        // R2 types: Skip, Empty, Random access never match
        do_op(3'd3, 0, 64'd0, 2'b00, 2'b00);
        do_op(3'd7, 2, '0, 2'b10, 2'b00);
        do_op(3'd7, 3, '0, 2'b01, 2'b00);
        do_op(3'd7, 4, '0, 2'b11, 2'b00);
        for (int k = 0; k < N; k++) begin
            do_op(3'd0, 0, pat(k), 2'b00, 2'b00);
            expect_search("R2 types");
        end
        read_check(4, "R9 set type");

        // R4/R5 duplicates
        do_op(3'd5, 6, pat(1), 2'b00, 2'b00);
        do_op(3'd5, 7, pat(1), 2'b00, 2'b00);
        do_op(3'd0, 0, pat(1), 2'b00, 2'b00);
        expect_search("R5 three copies");
        do_op(3'd7, 1, '0, 2'b10, 2'b00);
        do_op(3'd4, 0, '0, 2'b00, 2'b00);
        expect_search("R4 lowest after skip");
        do_op(3'd3, 0, 64'd1, 2'b00, 2'b00);
        expect_search("R8 assoc with split 1");

        // R10 flags hold across non-search ops
        f0 = {multi_match, match}; a0 = match_addr; d0 = assoc_data;
        do_op(3'd5, 6, 64'h1234_5678_9ABC_DEF0, 2'b00, 2'b00);
        do_op(3'd6, 7, '0, 2'b00, 2'b00);
        do_op(3'd7, 7, '0, 2'b01, 2'b00);
        f1 = {multi_match, match};
        check(f1 == f0 && match_addr == a0, "R10 flags held", W'({f1, match_addr}),
              W'({f0, a0}));
        check(assoc_data == d0, "R10 assoc held", assoc_data, d0);
        do_op(3'd4, 0, '0, 2'b00, 2'b00);
        expect_search("R10 refreshed");

        // R7 write protect
        do_op(3'd5, 0, 64'hAAAA_BBBB_CCCC_DDDD, 2'b00, 2'b10);
        read_check(0, "R7 protect mask B");
        do_op(3'd5, 5, 64'h1111_2222_3333_4444, 2'b00, 2'b01);
        read_check(5, "R7 protect mask A");
        do_op(3'd5, 5, 64'h5555_6666_7777_8888, 2'b00, 2'b11);
        read_check(5, "R7 no protect");
        do_op(3'd3, 0, 64'd0, 2'b00, 2'b00);
        do_op(3'd0, 0, 64'h5555_6666_7777_8888, 2'b00, 2'b00);
        expect_search("R7 written word found");

        finish_run();
    end

endmodule